// File: doc/BRIEF.md
# Host Transmit Byte Path with Status and Request

This block is the host-facing half of a parallel host-to-DSP mailbox. The host writes a data word one byte at a time into a high byte register and a low byte register. One of the two is the terminating byte, chosen by an endianness bit in the host control register. Writing the terminating byte marks the word as pending. On the first clock edge at which the DSP-side receive register is free, both bytes move into it together as one word. The receive register then stays full until the DSP reads it.

The host sees an 8-bit status register. It holds a transmit-empty flag, a transmitter-ready flag, two read-only mirrors of flags that the DSP sets in its own control register, and a DMA-active indication. A host request output follows transmit-empty when requests are enabled. The host can poll transmit-empty in either case. A host initialize pulse forces transmit-empty to set and drops any word that is still waiting for the receive register.

Top module: `host_tx_path`

## Requirements
- R1: After reset, host_status reads 8'h06 (transmit-empty and transmitter-ready set), host_req is 0, dsp_rx_full is 0 and all control fields are 0.
- R2: host_sel selects the target of a host write: 0 is control, 1 is the high byte, 2 is the low byte and 3 is status. The terminating byte is the low byte when control bit 1 (little_end) is 0 and the high byte when it is 1. Writing the terminating byte clears transmit-empty (status bit 1) at that edge.
- R3: A write to the non-terminating byte register changes only that byte and leaves transmit-empty unchanged.
- R4: While a word is pending, it moves into the receive register on the first edge at which dsp_rx_full is 0. At that edge dsp_rx_word becomes {high, low}, dsp_rx_full sets and transmit-empty sets. dsp_rx_full clears on the edge at which dsp_rd is high.
- R5: Status bit 2 (transmitter-ready) is 1 exactly when transmit-empty is 1 and the receive register is empty.
- R6: A host_init pulse sets transmit-empty at that edge, and the waiting word is never transferred. If host_init and a terminating write arrive in the same cycle, host_init wins.
- R7: host_req equals transmit-empty AND control bit 0 (request enable). Status bit 1 is valid whether or not requests are enabled.
- R8: Status bits 3 and 4 mirror dsp_flags[0] and dsp_flags[1]. They change only on an edge with dsp_ctl_we high. Host writes to status have no effect. Bits 0, 5 and 7 read 0.
- R9: Status bit 6 (DMA active) equals control bit 2 (dma_on) AND NOT control bit 3 (handshake off).
- R10: When a transfer and a new terminating write fall on the same edge, the receive register takes the previous word, the new byte is kept, and transmit-empty stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 2 | Host register select |
| host_wdata | input | BYTE_W | Host write data |
| host_init | input | 1 | Host initialize pulse |
| dsp_rd | input | 1 | DSP reads the receive register |
| dsp_ctl_we | input | 1 | DSP control register write strobe |
| dsp_flags | input | 2 | DSP-side flag values being written |
| host_status | output | 8 | Host-readable status register |
| host_req | output | 1 | Host request output |
| dsp_rx_word | output | 2*BYTE_W | DSP receive register contents |
| dsp_rx_full | output | 1 | DSP receive register holds a word |

## Verification
Two of this block's functions can fall on the same edge. The first is a transfer into the receive register together with a new terminating-byte write. The bench provokes it by leaving a word pending behind a full receive register, releasing it with a DSP read, and placing the next terminating write on the following edge. It is judged correct if the receive register takes the old word, transmit-empty stays 0, and the new word follows after one more read. The second is a host initialize together with a terminating write. It is judged correct if transmit-empty comes out set and no transfer ever occurs.

// File: rtl/hxmt_pkg.sv
package hxmt_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_HI   = 2'd1,
    SEL_LO   = 2'd2,
    SEL_STAT = 2'd3
  } hsel_e;

  typedef struct packed {
    logic hs_off;
    logic dma_on;
    logic little_end;
    logic treq_en;
  } hctl_t;

  localparam int CTL_W   = $bits(hctl_t);
  localparam int STAT_W  = 8;
  localparam int ST_TXE  = 1;
  localparam int ST_TRDY = 2;
  localparam int ST_F2   = 3;
  localparam int ST_F3   = 4;
  localparam int ST_DMA  = 6;

  // Terminating byte: low when little_end is 0, high when it is 1.
  function automatic logic is_term(input hsel_e sel, input logic little_end);
    return little_end ? (sel == SEL_HI) : (sel == SEL_LO);
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(
      input logic txe, input logic trdy, input logic f2,
      input logic f3, input logic dma);
    logic [STAT_W-1:0] s;
    s          = '0;
    s[ST_TXE]  = txe;
    s[ST_TRDY] = trdy;
    s[ST_F2]   = f2;
    s[ST_F3]   = f3;
    s[ST_DMA]  = dma;
    return s;
  endfunction

endpackage

// File: rtl/hxmt_byte_stage.sv
module hxmt_byte_stage
  import hxmt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  hsel_e             wr_sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              little_end,
  input  logic              init,
  input  logic              xfer,
  output logic [BYTE_W-1:0] hi_q,
  output logic [BYTE_W-1:0] lo_q,
  output logic              txe,
  output logic              term_wr
);

  logic hi_wr, lo_wr;

  assign hi_wr   = wr_en && (wr_sel == SEL_HI);
  assign lo_wr   = wr_en && (wr_sel == SEL_LO);
  assign term_wr = wr_en && is_term(wr_sel, little_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_wr) hi_q <= wdata;
      if (lo_wr) lo_q <= wdata;
    end
  end

  // Priority: init, then terminating write, then transfer.
  always_ff @(posedge clk) begin
    if (!rst_n)       txe <= 1'b1;
    else if (init)    txe <= 1'b1;
    else if (term_wr) txe <= 1'b0;
    else if (xfer)    txe <= 1'b1;
  end

  // R2
  term_clears_txe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_wr && !init |=> !txe);

  // R6
  init_sets_txe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> txe);

  // R3
  nonterm_keeps_txe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr || lo_wr) && !term_wr && !init && !xfer |=> $stable(txe));

endmodule

// File: rtl/hxmt_rx_slot.sv
module hxmt_rx_slot #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic              dsp_rd,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_full
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_word <= '0;
      rx_full <= 1'b0;
    end else if (load) begin
      rx_word <= word_in;
      rx_full <= 1'b1;
    end else if (dsp_rd) begin
      rx_full <= 1'b0;
    end
  end

  // R4
  load_captures_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rx_full && (rx_word == $past(word_in)));

  // R4
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && !dsp_rd |=> rx_full && $stable(rx_word));

endmodule

// File: rtl/hxmt_flag_mirror.sv
module hxmt_flag_mirror #(
  parameter int FLAG_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [FLAG_N-1:0] flags_in,
  output logic [FLAG_N-1:0] flags_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  flags_q <= '0;
    else if (we) flags_q <= flags_in;
  end

  // R8
  mirror_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(flags_q));

endmodule

// File: rtl/host_tx_path.sv
module host_tx_path
  import hxmt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic [1:0]          host_sel,
  input  logic [BYTE_W-1:0]   host_wdata,
  input  logic                host_init,
  input  logic                dsp_rd,
  input  logic                dsp_ctl_we,
  input  logic [1:0]          dsp_flags,
  output logic [7:0]          host_status,
  output logic                host_req,
  output logic [2*BYTE_W-1:0] dsp_rx_word,
  output logic                dsp_rx_full
);

  localparam int WORD_W = 2 * BYTE_W;

  hsel_e             sel;
  hctl_t             ctl;
  logic [BYTE_W-1:0] hi_q, lo_q;
  logic              txe, term_wr, xfer, trdy, dma_act;
  logic [1:0]        flags_q;

  assign sel = hsel_e'(host_sel);

  always_ff @(posedge clk) begin
    if (!rst_n)                            ctl <= '0;
    else if (host_wr && sel == SEL_CTRL)   ctl <= hctl_t'(host_wdata[CTL_W-1:0]);
  end

  // Named event: a pending word moves into the receive register.
  assign xfer = !txe && !dsp_rx_full && !host_init;

  hxmt_byte_stage #(.BYTE_W(BYTE_W)) u_bytes (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (host_wr),
    .wr_sel     (sel),
    .wdata      (host_wdata),
    .little_end (ctl.little_end),
    .init       (host_init),
    .xfer       (xfer),
    .hi_q       (hi_q),
    .lo_q       (lo_q),
    .txe        (txe),
    .term_wr    (term_wr)
  );

  hxmt_rx_slot #(.WORD_W(WORD_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (xfer),
    .word_in ({hi_q, lo_q}),
    .dsp_rd  (dsp_rd),
    .rx_word (dsp_rx_word),
    .rx_full (dsp_rx_full)
  );

  hxmt_flag_mirror #(.FLAG_N(2)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (dsp_ctl_we),
    .flags_in (dsp_flags),
    .flags_q  (flags_q)
  );

  assign trdy        = txe && !dsp_rx_full;
  assign dma_act     = ctl.dma_on && !ctl.hs_off;
  assign host_status = pack_status(txe, trdy, flags_q[0], flags_q[1], dma_act);
  assign host_req    = ctl.treq_en && txe;

  // R7
  req_implies_txe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_req |-> host_status[ST_TXE]);

  // R10
  collide_keeps_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && term_wr |=> !host_status[ST_TXE] && dsp_rx_full);

  // R5
  ready_needs_empty_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_status[ST_TRDY] |-> !dsp_rx_full);

  // R9
  dma_off_when_hs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.hs_off |-> !host_status[ST_DMA]);

endmodule

// File: tb/host_tx_path_bench.sv
`timescale 1ns/1ps
module host_tx_path_bench;

  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [7:0]  host_wdata = 8'h00;
  logic        host_init = 1'b0;
  logic        dsp_rd = 1'b0;
  logic        dsp_ctl_we = 1'b0;
  logic [1:0]  dsp_flags = 2'b00;
  logic [7:0]  host_status;
  logic        host_req;
  logic [15:0] dsp_rx_word;
  logic        dsp_rx_full;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  host_tx_path u_host_tx_path (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_init(host_init), .dsp_rd(dsp_rd),
    .dsp_ctl_we(dsp_ctl_we), .dsp_flags(dsp_flags), .host_status(host_status),
    .host_req(host_req), .dsp_rx_word(dsp_rx_word), .dsp_rx_full(dsp_rx_full)
  );

  // {little_end, hi, lo, expected word}
  localparam logic [32:0] VEC [0:5] = '{
    {1'b0, 8'hA5, 8'h3C, 16'hA53C},
    {1'b1, 8'h12, 8'h34, 16'h1234},
    {1'b0, 8'h00, 8'hFF, 16'h00FF},
    {1'b1, 8'hFF, 8'h00, 16'hFF00},
    {1'b0, 8'h80, 8'h01, 16'h8001},
    {1'b1, 8'h5A, 8'hC3, 16'h5AC3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    tick();
    host_wr = 1'b0;
  endtask

  task automatic dread();
    dsp_rd = 1'b1;
    tick();
    dsp_rd = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", host_status, 8'h06);
    chk("R1 req", host_req, 1'b0);
    chk("R1 full", dsp_rx_full, 1'b0);

    // Table walk: R2 R3 R4 R5 R7
    for (int i = 0; i < 6; i++) begin
      logic le;
      logic [7:0] hi, lo;
      logic [15:0] ew;
      {le, hi, lo, ew} = VEC[i];
      wr(2'd0, {6'd0, le, 1'b1});
      chk("R7 req idle", host_req, 1'b1);
      if (le) wr(2'd2, lo); else wr(2'd1, hi);
      chk("R3 nonterm keeps txe", host_status[1], 1'b1);
      if (le) wr(2'd1, hi); else wr(2'd2, lo);
      chk("R2 term clears txe", host_status[1], 1'b0);
      chk("R5 trdy low pending", host_status[2], 1'b0);
      chk("R7 req follows txe", host_req, 1'b0);
      tick();
      chk("R4 full", dsp_rx_full, 1'b1);
      chk("R4 word", dsp_rx_word, ew);
      chk("R4 txe set", host_status[1], 1'b1);
      chk("R5 trdy low rx full", host_status[2], 1'b0);
      dread();
      chk("R4 read empties", dsp_rx_full, 1'b0);
      chk("R5 trdy back", host_status[2], 1'b1);
    end

    // R7 request disabled, txe still polled
    wr(2'd0, 8'h00);
    chk("R7 req off", host_req, 1'b0);
    chk("R7 txe polled", host_status[1], 1'b1);

    // R8 flag mirrors
    dsp_flags = 2'b11; dsp_ctl_we = 1'b1; tick(); dsp_ctl_we = 1'b0;
    chk("R8 flags set", host_status, 8'h1E);
    dsp_flags = 2'b00; tick();
    chk("R8 no we", host_status, 8'h1E);
    wr(2'd3, 8'hFF);
    chk("R8 host write ignored", host_status, 8'h1E);
    dsp_flags = 2'b01; dsp_ctl_we = 1'b1; tick(); dsp_ctl_we = 1'b0;
    chk("R8 flag2 only", host_status, 8'h0E);
    dsp_flags = 2'b00; dsp_ctl_we = 1'b1; tick(); dsp_ctl_we = 1'b0;

    // R9 DMA active
    wr(2'd0, 8'h04);
    chk("R9 dma on", host_status, 8'h46);
    wr(2'd0, 8'h0C);
    chk("R9 hs off", host_status, 8'h06);
    wr(2'd0, 8'h00);

    // R10 transfer collides with terminating write
    wr(2'd1, 8'hAA); wr(2'd2, 8'h55); tick();
    chk("R4 first word", dsp_rx_word, 16'hAA55);
    wr(2'd1, 8'hBB); wr(2'd2, 8'hCC); tick();
    chk("R4 held while full", dsp_rx_word, 16'hAA55);
    chk("R4 pending txe", host_status[1], 1'b0);
    dread();
    chk("R4 empty after read", dsp_rx_full, 1'b0);
    wr(2'd2, 8'hDD);
    chk("R10 old word taken", dsp_rx_word, 16'hBBCC);
    chk("R10 full", dsp_rx_full, 1'b1);
    chk("R10 txe stays 0", host_status[1], 1'b0);
    dread();
    tick();
    chk("R10 new word", dsp_rx_word, 16'hBBDD);
    chk("R10 txe set", host_status[1], 1'b1);

    // R6 initialize discards pending word
    wr(2'd1, 8'h11); wr(2'd2, 8'h22);
    chk("R6 pending", host_status[1], 1'b0);
    host_init = 1'b1; tick(); host_init = 1'b0;
    chk("R6 init sets txe", host_status[1], 1'b1);
    dread(); tick(); tick();
    chk("R6 no transfer", dsp_rx_full, 1'b0);
    chk("R6 word kept", dsp_rx_word, 16'hBBDD);
    // R6 init and terminating write together
    host_init = 1'b1; wr(2'd2, 8'h33); host_init = 1'b0;
    chk("R6 init wins", host_status[1], 1'b1);
    tick(); tick();
    chk("R6 still empty", dsp_rx_full, 1'b0);

    // R1 reset again mid-run
    wr(2'd0, 8'h05);
    rst_n = 1'b0; tick(); rst_n = 1'b1;
    chk("R1 reset clears ctl", host_status, 8'h06);
    chk("R1 reset req", host_req, 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule